// File: doc/BRIEF.md
# Program Sequencer with Data-RAM Return Stack

This block produces the instruction address for a small 4-bit controller core. A program counter either steps by one, takes a jump target (a whole or partial load from an immediate field or from a data register), takes a call target, or returns from a subroutine. Return addresses are not kept in a dedicated stack. They live in the top registers of the general data register file, counted downward from the highest register as the nesting depth grows. A return loads the stored address plus two.

The decoder is outside this block. It presents one-cycle strobes for step, jump, call and return. A general access port lets ordinary instructions read and write the same registers. A call made while the stack is already at its deepest slot, a return made with an empty stack, or a call and return strobed together is treated as a runaway program. The block then clears the program counter and stack pointer and raises a one-cycle internal reset flag. The register contents survive both that fault and the external resets.

Top module: `pseq_top`

## Requirements
- R1: While `rst` or `clr_all` is high at a clock edge, `pc_o` becomes 0, `sp_o` becomes 0 and `cpu_rst_o` becomes 0 after that edge. All strobes are ignored in that cycle, and no stack write occurs.
- R2: `step_i` alone increments `pc_o` by one after the edge, and the value wraps from 2^PC_W-1 to 0.
- R3: With `jump_i` and `jmp_src_i`=0, each `pc_o` bit whose `jmp_mask_i` bit is 1 takes the matching `jmp_imm_i` bit, and the other bits keep their value.
- R4: With `jump_i` and `jmp_src_i`=1, the masked bits come from the low PC_W bits of register `jmp_reg_i`.
- R5: A legal call (`sp_o` below its maximum) writes `pc_o`+1, zero-extended, into register NREGS-1-`sp_o`. It then increments `sp_o` and loads `call_tgt_i` into `pc_o`.
- R6: A legal return (`sp_o` nonzero) decrements `sp_o` and loads (register NREGS-`sp_o`) + 2 into `pc_o`.
- R7: A call while `sp_o` is at its maximum (3 by default) writes nothing. After the edge, `pc_o`=0, `sp_o`=0 and `cpu_rst_o`=1 for exactly one cycle.
- R8: A return while `sp_o`=0 produces the same fault: `pc_o`=0, `sp_o`=0 and a one-cycle `cpu_rst_o`.
- R9: `call_i` and `ret_i` high in the same cycle is a fault with the outcome of R7, whatever the value of `sp_o`.
- R10: Priority is fault, then call, then return, then jump, then step, with `rst`/`clr_all` above all of them.
- R11: The general port writes `gp_wdata_i` to `gp_addr_i` when `gp_we_i` is high. `gp_rdata_o` shows register `gp_addr_i` one cycle later. A call write in the same cycle wins, and the general write is dropped.
- R12: Register contents are kept through `rst`, `clr_all` and the internal fault reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Synchronous all-clear, same effect as rst on the sequencer |
| step_i | input | 1 | Advance the program counter by one |
| jump_i | input | 1 | Jump strobe |
| jmp_src_i | input | 1 | Jump source: 0 immediate, 1 data register |
| jmp_mask_i | input | PC_W | Bits of the program counter that the jump replaces |
| jmp_imm_i | input | PC_W | Immediate jump target |
| jmp_reg_i | input | clog2(NREGS) | Register holding a jump target |
| call_i | input | 1 | Call strobe |
| call_tgt_i | input | PC_W | Call target |
| ret_i | input | 1 | Return strobe |
| gp_we_i | input | 1 | General register write enable |
| gp_addr_i | input | clog2(NREGS) | General register address |
| gp_wdata_i | input | 2*WORD_W | General register write data |
| gp_rdata_o | output | 2*WORD_W | General register read data, one cycle latency |
| pc_o | output | PC_W | Program counter |
| sp_o | output | clog2(DEPTH) | Stack pointer |
| cpu_rst_o | output | 1 | One-cycle internal reset after a stack fault |

## Verification
The bench builds two copies of the block. The main copy uses the default 10-bit program counter, 5-bit words, sixteen registers and four stack levels, so every stack level, both fault edges and the jump paths are all reachable with a few strobes. A second copy with a 9-bit program counter is driven with the same step and jump strobes. It shows that the wrap point moves with PC_W: 511 steps to 0 there, while 1023 steps to 0 on the main copy.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_STEP,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET,
    ACT_FAULT
  } act_e;

  // Arbitrate the decoder strobes into one action for this cycle.
  function automatic act_e pick_action(input logic call, input logic ret,
                                       input logic jump, input logic step,
                                       input logic sp_full, input logic sp_empty);
    act_e a;
    if (call && ret)       a = ACT_FAULT;
    else if (call)         a = sp_full  ? ACT_FAULT : ACT_CALL;
    else if (ret)          a = sp_empty ? ACT_FAULT : ACT_RET;
    else if (jump)         a = ACT_JUMP;
    else if (step)         a = ACT_STEP;
    else                   a = ACT_IDLE;
    return a;
  endfunction

endpackage

// File: rtl/pseq_regfile.sv
module pseq_regfile #(
  parameter int NREGS = 16,
  parameter int REG_W = 10,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [AW-1:0]    stk_addr,
  output logic [REG_W-1:0] stk_data,
  input  logic [AW-1:0]    jmp_addr,
  output logic [REG_W-1:0] jmp_data,
  input  logic [AW-1:0]    gp_addr,
  output logic [REG_W-1:0] gp_data
);

  logic [REG_W-1:0] mem [NREGS];

  // Contents are never reset: they must survive every reset source.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    gp_data <= mem[gp_addr];
  end

  assign stk_data = mem[stk_addr];
  assign jmp_data = mem[jmp_addr];

endmodule

// File: rtl/pseq_sp.sv
module pseq_sp
  import pseq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  act_e            act,
  output logic [SP_W-1:0] sp_q,
  output logic            fault_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= (act == ACT_FAULT);
      case (act)
        ACT_FAULT: sp_q <= '0;
        ACT_CALL:  sp_q <= sp_q + SP_W'(1);
        ACT_RET:   sp_q <= sp_q - SP_W'(1);
        default:   sp_q <= sp_q;
      endcase
    end
  end

endmodule

// File: rtl/pseq_pc.sv
module pseq_pc
  import pseq_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int REG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  act_e             act,
  input  logic [PC_W-1:0]  call_tgt,
  input  logic             jmp_src,
  input  logic [PC_W-1:0]  jmp_mask,
  input  logic [PC_W-1:0]  jmp_imm,
  input  logic [REG_W-1:0] jmp_reg_val,
  input  logic [REG_W-1:0] ret_val,
  output logic [PC_W-1:0]  pc_q
);

  logic [PC_W-1:0] jmp_tgt;
  logic [PC_W-1:0] pc_nxt;

  always_comb begin
    jmp_tgt = jmp_src ? jmp_reg_val[PC_W-1:0] : jmp_imm;
    case (act)
      ACT_FAULT: pc_nxt = '0;
      ACT_CALL:  pc_nxt = call_tgt;
      ACT_RET:   pc_nxt = ret_val[PC_W-1:0] + PC_W'(2);
      ACT_JUMP:  pc_nxt = (pc_q & ~jmp_mask) | (jmp_tgt & jmp_mask);
      ACT_STEP:  pc_nxt = pc_q + PC_W'(1);
      default:   pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int WORD_W = 5,
  parameter int NREGS  = 16,
  parameter int DEPTH  = 4,
  localparam int REG_W = 2 * WORD_W,
  localparam int RA_W  = $clog2(NREGS),
  localparam int SP_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             step_i,
  input  logic             jump_i,
  input  logic             jmp_src_i,
  input  logic [PC_W-1:0]  jmp_mask_i,
  input  logic [PC_W-1:0]  jmp_imm_i,
  input  logic [RA_W-1:0]  jmp_reg_i,
  input  logic             call_i,
  input  logic [PC_W-1:0]  call_tgt_i,
  input  logic             ret_i,
  input  logic             gp_we_i,
  input  logic [RA_W-1:0]  gp_addr_i,
  input  logic [REG_W-1:0] gp_wdata_i,
  output logic [REG_W-1:0] gp_rdata_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             cpu_rst_o
);

  localparam logic [RA_W-1:0] TOP_REG = RA_W'(NREGS - 1);

  logic             rst_any;
  act_e             act;
  logic [SP_W-1:0]  sp_dec;
  logic [RA_W-1:0]  push_slot;
  logic [RA_W-1:0]  pop_slot;
  logic             rf_we;
  logic [RA_W-1:0]  rf_waddr;
  logic [REG_W-1:0] rf_wdata;
  logic [REG_W-1:0] stk_rd;
  logic [REG_W-1:0] jreg_rd;
  logic [PC_W-1:0]  pc_inc;

  assign rst_any = rst | clr_all;

  always_comb begin
    if (rst_any) act = ACT_IDLE;
    else act = pick_action(call_i, ret_i, jump_i, step_i,
                           (sp_o == '1), (sp_o == '0));
  end

  // Stack slots grow downward from the highest register.
  assign sp_dec    = sp_o - SP_W'(1);
  assign push_slot = TOP_REG - RA_W'(sp_o);
  assign pop_slot  = TOP_REG - RA_W'(sp_dec);
  assign pc_inc    = pc_o + PC_W'(1);

  // One write port: a call push takes it over from the general port.
  always_comb begin
    if (act == ACT_CALL) begin
      rf_we    = 1'b1;
      rf_waddr = push_slot;
      rf_wdata = REG_W'(pc_inc);
    end else begin
      rf_we    = gp_we_i;
      rf_waddr = gp_addr_i;
      rf_wdata = gp_wdata_i;
    end
  end

  pseq_regfile #(.NREGS(NREGS), .REG_W(REG_W)) u_rf (
    .clk      (clk),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .stk_addr (pop_slot),
    .stk_data (stk_rd),
    .jmp_addr (jmp_reg_i),
    .jmp_data (jreg_rd),
    .gp_addr  (gp_addr_i),
    .gp_data  (gp_rdata_o)
  );

  pseq_sp #(.DEPTH(DEPTH)) u_sp (
    .clk     (clk),
    .rst     (rst_any),
    .act     (act),
    .sp_q    (sp_o),
    .fault_q (cpu_rst_o)
  );

  pseq_pc #(.PC_W(PC_W), .REG_W(REG_W)) u_pc (
    .clk         (clk),
    .rst         (rst_any),
    .act         (act),
    .call_tgt    (call_tgt_i),
    .jmp_src     (jmp_src_i),
    .jmp_mask    (jmp_mask_i),
    .jmp_imm     (jmp_imm_i),
    .jmp_reg_val (jreg_rd),
    .ret_val     (stk_rd),
    .pc_q        (pc_o)
  );

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
  parameter int PC_W = 10,
  parameter int SP_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            clr_all,
  input logic            step_i,
  input logic            jump_i,
  input logic            call_i,
  input logic            ret_i,
  input logic [PC_W-1:0] call_tgt_i,
  input logic [PC_W-1:0] pc_o,
  input logic [SP_W-1:0] sp_o,
  input logic            cpu_rst_o
);

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (pc_o == '0 && sp_o == '0 && !cpu_rst_o));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && step_i && !jump_i && !call_i && !ret_i)
    |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

  p_call_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && call_i && !ret_i && sp_o != '1)
    |=> (sp_o == SP_W'($past(sp_o) + SP_W'(1)) && pc_o == $past(call_tgt_i)));

  p_ret_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && ret_i && !call_i && sp_o != '0)
    |=> sp_o == SP_W'($past(sp_o) - SP_W'(1)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && call_i && !ret_i && sp_o == '1)
    |=> (cpu_rst_o && pc_o == '0 && sp_o == '0));

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && ret_i && !call_i && sp_o == '0)
    |=> (cpu_rst_o && pc_o == '0 && sp_o == '0));

  p_call_ret_clash_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && call_i && ret_i) |=> cpu_rst_o);

  p_fault_state_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_o |-> (pc_o == '0 && sp_o == '0));

endmodule

bind pseq_top pseq_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_all    (clr_all),
  .step_i     (step_i),
  .jump_i     (jump_i),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .call_tgt_i (call_tgt_i),
  .pc_o       (pc_o),
  .sp_o       (sp_o),
  .cpu_rst_o  (cpu_rst_o)
);

// File: tb/pseq_top_tb_top.sv
`timescale 1ns/1ps
module pseq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst, clr;
  logic       step, jump, jsrc, call, ret, gwe;
  logic [9:0] jmask, jimm, ctgt, gwd;
  logic [3:0] jreg, gaddr;
  logic [9:0] gq, pc;
  logic [1:0] sp;
  logic       crst;
  logic [8:0] jimm9, pc9;
  logic [9:0] gq9;
  logic [1:0] sp9;
  logic       crst9;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pseq_top dut_i (
    .clk(clk), .rst(rst), .clr_all(clr), .step_i(step), .jump_i(jump),
    .jmp_src_i(jsrc), .jmp_mask_i(jmask), .jmp_imm_i(jimm), .jmp_reg_i(jreg),
    .call_i(call), .call_tgt_i(ctgt), .ret_i(ret), .gp_we_i(gwe),
    .gp_addr_i(gaddr), .gp_wdata_i(gwd), .gp_rdata_o(gq), .pc_o(pc),
    .sp_o(sp), .cpu_rst_o(crst)
  );

  pseq_top #(.PC_W(9)) dut9_i (
    .clk(clk), .rst(rst), .clr_all(clr), .step_i(step), .jump_i(jump),
    .jmp_src_i(1'b0), .jmp_mask_i(9'h1FF), .jmp_imm_i(jimm9), .jmp_reg_i(jreg),
    .call_i(1'b0), .call_tgt_i(9'h000), .ret_i(1'b0), .gp_we_i(1'b0),
    .gp_addr_i(gaddr), .gp_wdata_i(gwd), .gp_rdata_o(gq9), .pc_o(pc9),
    .sp_o(sp9), .cpu_rst_o(crst9)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    step = 0; jump = 0; jsrc = 0; call = 0; ret = 0; gwe = 0; clr = 0;
    jmask = '0; jimm = '0; ctgt = '0; jreg = '0; gwd = '0; jimm9 = '0;
  endtask

  task automatic clear();
    idle(); clr = 1; tick(); clr = 0;
  endtask

  task automatic set_pc(input logic [9:0] v);
    idle(); jump = 1; jmask = 10'h3FF; jimm = v; tick(); idle();
  endtask

  task automatic gp_write(input logic [3:0] a, input logic [9:0] d);
    idle(); gwe = 1; gaddr = a; gwd = d; tick(); idle();
  endtask

  task automatic gp_read(input logic [3:0] a, output logic [9:0] d);
    idle(); gaddr = a; tick(); d = gq;
  endtask

  task automatic do_call(input logic [9:0] t);
    idle(); call = 1; ctgt = t; tick(); idle();
  endtask

  task automatic do_ret();
    idle(); ret = 1; tick(); idle();
  endtask

  task automatic t_reset();
    chk("R1 pc after reset", pc, 0);
    chk("R1 sp after reset", sp, 0);
    chk("R1 cpu_rst after reset", crst, 0);
  endtask

  task automatic t_step();
    clear();
    for (int i = 0; i < 5; i++) begin
      idle(); step = 1; tick();
    end
    idle();
    chk("R2 five steps", pc, 5);
    idle(); jump = 1; jmask = 10'h3FF; jimm = 10'h3FF; jimm9 = 9'h1FF; tick(); idle();
    chk("R2 pc at top (10b)", pc, 10'h3FF);
    chk("R2 pc at top (9b)", pc9, 9'h1FF);
    idle(); step = 1; tick(); idle();
    chk("R2 wrap 10b", pc, 0);
    chk("R2 wrap 9b", pc9, 0);
  endtask

  task automatic t_jump_imm();
    clear();
    set_pc(10'h155);
    idle(); jump = 1; jmask = 10'h00F; jimm = 10'h03A; tick(); idle();
    chk("R3 partial immediate jump", pc, 10'h15A);
  endtask

  task automatic t_jump_reg();
    logic [9:0] d;
    clear();
    gp_write(4'd3, 10'h2C7);
    gp_read(4'd3, d);
    chk("R11 general readback", d, 10'h2C7);
    set_pc(10'h011);
    idle(); jump = 1; jsrc = 1; jreg = 4'd3; jmask = 10'h3F0; tick(); idle();
    chk("R4 partial register jump", pc, 10'h2C1);
  endtask

  task automatic t_call_ret();
    logic [9:0] d;
    clear();
    set_pc(10'h100);
    do_call(10'h200);
    chk("R5 call target", pc, 10'h200);
    chk("R5 sp after call", sp, 1);
    gp_read(4'd15, d);
    chk("R5 return address in top reg", d, 10'h101);
    do_call(10'h300);
    chk("R5 sp after second call", sp, 2);
    gp_read(4'd14, d);
    chk("R5 return address in next reg", d, 10'h201);
    do_ret();
    chk("R6 return pc", pc, 10'h203);
    chk("R6 sp after return", sp, 1);
    do_ret();
    chk("R6 outer return pc", pc, 10'h103);
    chk("R6 sp empty", sp, 0);
  endtask

  task automatic t_overflow();
    logic [9:0] d;
    clear();
    gp_write(4'd12, 10'h155);
    do_call(10'h010);
    do_call(10'h020);
    do_call(10'h030);
    chk("R7 sp at max", sp, 3);
    do_call(10'h040);
    chk("R7 overflow pc", pc, 0);
    chk("R7 overflow sp", sp, 0);
    chk("R7 overflow pulse", crst, 1);
    tick();
    chk("R7 pulse one cycle", crst, 0);
    gp_read(4'd12, d);
    chk("R7 no write on overflow", d, 10'h155);
  endtask

  task automatic t_underflow();
    clear();
    set_pc(10'h02A);
    do_ret();
    chk("R8 underflow pc", pc, 0);
    chk("R8 underflow sp", sp, 0);
    chk("R8 underflow pulse", crst, 1);
    tick();
    chk("R8 pulse one cycle", crst, 0);
  endtask

  task automatic t_clash();
    clear();
    set_pc(10'h040);
    idle(); call = 1; ret = 1; ctgt = 10'h099; tick(); idle();
    chk("R9 clash pc", pc, 0);
    chk("R9 clash sp", sp, 0);
    chk("R9 clash pulse", crst, 1);
  endtask

  task automatic t_priority();
    logic [9:0] d;
    clear();
    set_pc(10'h010);
    idle(); call = 1; ctgt = 10'h080; jump = 1; jmask = 10'h3FF; jimm = 10'h3FF; step = 1;
    tick(); idle();
    chk("R10 call beats jump/step", pc, 10'h080);
    chk("R10 call sp", sp, 1);
    idle(); jump = 1; jmask = 10'h3FF; jimm = 10'h022; step = 1; tick(); idle();
    chk("R10 jump beats step", pc, 10'h022);
    idle(); ret = 1; jump = 1; jmask = 10'h3FF; jimm = 10'h1EE; tick(); idle();
    chk("R10 return beats jump", pc, 10'h013);
    gp_write(4'd15, 10'h0AA);
    idle(); clr = 1; call = 1; ctgt = 10'h077; tick(); idle();
    chk("R10 clear beats call pc", pc, 0);
    chk("R10 clear beats call sp", sp, 0);
    chk("R1 clear gives no pulse", crst, 0);
    gp_read(4'd15, d);
    chk("R1 no stack write under clear", d, 10'h0AA);
  endtask

  task automatic t_port_clash();
    logic [9:0] d;
    clear();
    set_pc(10'h050);
    gp_write(4'd5, 10'h3C3);
    idle(); call = 1; ctgt = 10'h060; gwe = 1; gaddr = 4'd5; gwd = 10'h0F0; tick(); idle();
    gp_read(4'd15, d);
    chk("R11 call push wins port", d, 10'h051);
    gp_read(4'd5, d);
    chk("R11 general write dropped", d, 10'h3C3);
  endtask

  task automatic t_retain();
    logic [9:0] d;
    clear();
    gp_write(4'd7, 10'h2B4);
    set_pc(10'h123);
    idle(); rst = 1; tick(); rst = 0;
    chk("R1 reset clears pc", pc, 0);
    gp_read(4'd7, d);
    chk("R12 register kept over reset", d, 10'h2B4);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    idle(); gaddr = '0; rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_step();
    t_jump_imm();
    t_jump_reg();
    t_call_ret();
    t_overflow();
    t_underflow();
    t_clash();
    t_priority();
    t_port_clash();
    t_retain();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule